// File: doc/BRIEF.md
# Inverting Bus Transceiver with Address Comparator

This block sits between a 4-line system bus and the data lines of a peripheral. The bus is wire-AND and active low: a line that is low carries a logical 1. Each unit drives a bus line only by pulling it low, and that pull is shown as an enable bit. The peripheral lines are active high and are driven as a group under one output enable. Levels are inverted in both directions, so the logical value is the same on both sides. Two control inputs choose the mode: receive (bus to peripheral), transmit (peripheral to bus) or disable.

Two more functions share the bus lines. The first is an address comparator. It checks logical bus lines 3 to 1 against three jumpers, and each jumper can be marked don't-care. The result is gated by a match enable and leaves the block as an open-collector pull, so several units can share one wire-AND match line. The second is a set of three vector jumpers. These pull bus lines 3 to 1 in every mode and can supply a constant such as an interrupt vector.

Mode changes are break-before-make. When a driving mode is left, both sides stay undriven for a guard interval counted in clocks, and only then can the other side drive.

Top module: `xcvr4_addr_match`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the block is in disable mode: `per_oe` is 0 and `bus_pull` carries only the vector pulls.
- R2: `ctl_rx`=1,`ctl_tx`=0 requests receive. `ctl_rx`=0,`ctl_tx`=1 requests transmit. Both 0 or both 1 requests disable.
- R3: In receive mode `per_oe` is 1 and `per_out` equals `~bus_in`. `per_in` has no effect on `bus_pull`.
- R4: In transmit mode `per_oe` is 0, and `bus_pull[i]` is 1 wherever `per_in[i]` is 1.
- R5: In disable mode `per_oe` is 0, `per_out` is 0, and no data pull is asserted.
- R6: `vec_jmp[k]`=1 sets `bus_pull[k+1]` (k = 0..2) in every mode. `bus_pull[0]` is never set by a vector jumper.
- R7: With `match_en`=1, `match_pull` is 0 exactly when every address bit k with `adr_care[k]`=1 has `adr_val[k]` equal to `~bus_in[k+1]`. Bus line 0 never affects the result.
- R8: An address bit with `adr_care[k]`=0 is excluded from the comparison. With all care bits 0 the unit always matches.
- R9: With `match_en`=0, `match_pull` is 1 whatever the address.
- R10: On a switch from one driving mode to the other, both data sides are undriven for GUARD_CYC+1 clock edges. The new mode drives from edge GUARD_CYC+2 after the request.
- R11: A mode requested from disable, with the guard expired, takes effect on the next clock edge. A disable request takes effect on the next clock edge, and a driving mode requested during the guard waits until the guard expires.
- R12: `per_oe` and any data pull on `bus_pull` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_rx | input | 1 | Receive request |
| ctl_tx | input | 1 | Transmit request |
| bus_in | input | 4 | Bus line levels (low = logical 1) |
| bus_pull | output | 4 | Per-line pull-low enable toward the bus |
| per_in | input | 4 | Peripheral line levels (high = 1) |
| per_out | output | 4 | Peripheral drive value |
| per_oe | output | 1 | Peripheral output enable |
| vec_jmp | input | 3 | Vector jumpers for bus lines 3..1 |
| adr_val | input | 3 | Address jumper values for bus lines 3..1 |
| adr_care | input | 3 | Address jumper care flags (0 = don't care) |
| match_en | input | 1 | Match output enable |
| match_pull | output | 1 | Pulls the shared match line low when there is no match |

## Verification
The vector table runs the datapath in each steady mode with asymmetric bit patterns, so that a missing inversion or a swapped line shows up in `per_out` or `bus_pull`. Address patterns cover a full-care hit, a full-care miss, a miss rescued by don't-care bits, all bits don't-care, and a difference on bus line 0 only. The last of these separates a comparator that is off by one line from a correct one. Directed sequences time the guard edge by edge for a swap between driving modes, for an entry from settled disable, and for a drive request made while the guard is still counting.

// File: rtl/xcvr4_pkg.sv
package xcvr4_pkg;

    typedef enum logic [1:0] {
        XM_OFF = 2'd0,
        XM_RX  = 2'd1,
        XM_TX  = 2'd2
    } xm_mode_e;

    typedef struct packed {
        logic care;
        logic val;
    } adr_jmp_t;

    function automatic xm_mode_e decode_mode(input logic rx, input logic tx);
        if (rx && !tx)      return XM_RX;
        else if (tx && !rx) return XM_TX;
        else                return XM_OFF;
    endfunction

    function automatic logic jmp_hit(input adr_jmp_t j, input logic bus_level);
        return !j.care || (j.val == !bus_level);
    endfunction

endpackage

// File: rtl/xcvr_mode_seq.sv
module xcvr_mode_seq
    import xcvr4_pkg::*;
#(
    parameter int GUARD_CYC = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ctl_rx,
    input  logic     ctl_tx,
    output xm_mode_e act
);
    localparam int CW = $clog2(GUARD_CYC + 1) + 1;

    xm_mode_e      req;
    logic [CW-1:0] gcnt;

    assign req = decode_mode(ctl_rx, ctl_tx);

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= XM_OFF;
            gcnt <= '0;
        end else if (act != XM_OFF) begin
            if (req != act) begin
                act  <= XM_OFF;
                gcnt <= CW'(GUARD_CYC);
            end
        end else if (gcnt != '0) begin
            gcnt <= gcnt - 1'b1;
        end else if (req != XM_OFF) begin
            act <= req;
        end
    end
endmodule

// File: rtl/xcvr_data_path.sv
module xcvr_data_path
    import xcvr4_pkg::*;
#(
    parameter int W = 4
) (
    input  xm_mode_e     act,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] per_in,
    input  logic [W-2:0] vec_jmp,
    output logic [W-1:0] per_out,
    output logic         per_oe,
    output logic [W-1:0] bus_pull
);
    logic rx_on, tx_on;

    assign rx_on   = (act == XM_RX);
    assign tx_on   = (act == XM_TX);
    assign per_oe  = rx_on;
    assign per_out = rx_on ? ~bus_in : '0;

    for (genvar i = 0; i < W; i++) begin : g_line
        if (i == 0) begin : g_plain
            assign bus_pull[i] = tx_on && per_in[i];
        end else begin : g_vec
            assign bus_pull[i] = (tx_on && per_in[i]) || vec_jmp[i-1];
        end
    end
endmodule

// File: rtl/xcvr_addr_cmp.sv
module xcvr_addr_cmp
    import xcvr4_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic [AW:0]   bus_in,
    input  logic [AW-1:0] adr_val,
    input  logic [AW-1:0] adr_care,
    input  logic          match_en,
    output logic          match_pull
);
    logic [AW-1:0] hit;

    for (genvar k = 0; k < AW; k++) begin : g_bit
        adr_jmp_t j;
        assign j.care = adr_care[k];
        assign j.val  = adr_val[k];
        assign hit[k] = jmp_hit(j, bus_in[k+1]);
    end

    assign match_pull = !(match_en && (&hit));
endmodule

// File: rtl/xcvr4_addr_match.sv
module xcvr4_addr_match
    import xcvr4_pkg::*;
#(
    parameter int W         = 4,
    parameter int GUARD_CYC = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl_rx,
    input  logic         ctl_tx,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_pull,
    input  logic [W-1:0] per_in,
    output logic [W-1:0] per_out,
    output logic         per_oe,
    input  logic [W-2:0] vec_jmp,
    input  logic [W-2:0] adr_val,
    input  logic [W-2:0] adr_care,
    input  logic         match_en,
    output logic         match_pull
);
    localparam int AW = W - 1;

    xm_mode_e act_mode;

    xcvr_mode_seq #(.GUARD_CYC(GUARD_CYC)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .ctl_rx (ctl_rx),
        .ctl_tx (ctl_tx),
        .act    (act_mode)
    );

    xcvr_data_path #(.W(W)) u_data (
        .act      (act_mode),
        .bus_in   (bus_in),
        .per_in   (per_in),
        .vec_jmp  (vec_jmp),
        .per_out  (per_out),
        .per_oe   (per_oe),
        .bus_pull (bus_pull)
    );

    xcvr_addr_cmp #(.AW(AW)) u_cmp (
        .bus_in     (bus_in),
        .adr_val    (adr_val),
        .adr_care   (adr_care),
        .match_en   (match_en),
        .match_pull (match_pull)
    );
endmodule

// File: rtl/xcvr4_addr_match_chk.sv
module xcvr4_addr_match_chk
    import xcvr4_pkg::*;
#(
    parameter int W         = 4,
    parameter int GUARD_CYC = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         ctl_rx,
    input logic         ctl_tx,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] bus_pull,
    input logic [W-1:0] per_out,
    input logic         per_oe,
    input logic [W-2:0] vec_jmp,
    input logic [W-2:0] adr_val,
    input logic [W-2:0] adr_care,
    input logic         match_en,
    input logic         match_pull,
    input xm_mode_e     act
);
    localparam int OCW = $clog2(GUARD_CYC + 3) + 1;
    localparam logic [OCW-1:0] OMAX = {OCW{1'b1}};

    logic [OCW-1:0] off_cnt;
    logic           ever_drv;
    logic [W-1:0]   vec_mask;

    assign vec_mask = {vec_jmp, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            off_cnt  <= '0;
            ever_drv <= 1'b0;
        end else begin
            if (act == XM_OFF) off_cnt <= (off_cnt == OMAX) ? off_cnt : off_cnt + 1'b1;
            else               off_cnt <= '0;
            if (act != XM_OFF) ever_drv <= 1'b1;
        end
    end

    // R3
    p_rx_data_r3: assert property (@(posedge clk) disable iff (rst)
        per_oe |-> (per_out == ~bus_in));

    // R2
    p_both_off_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl_rx) && $past(ctl_tx)) |-> !per_oe);

    // R6
    p_vec_r6: assert property (@(posedge clk) disable iff (rst)
        ((bus_pull[W-1:1] & vec_jmp) == vec_jmp));

    // R7
    p_hit_r7: assert property (@(posedge clk) disable iff (rst)
        (match_en && (&adr_care) && (adr_val == ~bus_in[W-1:1])) |-> !match_pull);

    // R9
    p_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !match_en |-> match_pull);

    // R10
    p_guard_r10: assert property (@(posedge clk) disable iff (rst)
        (act != XM_OFF && ever_drv && off_cnt != '0) |-> (off_cnt >= OCW'(GUARD_CYC + 1)));

    // R12
    p_no_overlap_r12: assert property (@(posedge clk) disable iff (rst)
        per_oe |-> ((bus_pull & ~vec_mask) == '0));
endmodule

bind xcvr4_addr_match xcvr4_addr_match_chk #(.W(W), .GUARD_CYC(GUARD_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_rx     (ctl_rx),
    .ctl_tx     (ctl_tx),
    .bus_in     (bus_in),
    .bus_pull   (bus_pull),
    .per_out    (per_out),
    .per_oe     (per_oe),
    .vec_jmp    (vec_jmp),
    .adr_val    (adr_val),
    .adr_care   (adr_care),
    .match_en   (match_en),
    .match_pull (match_pull),
    .act        (act_mode)
);

// File: tb/xcvr4_addr_match_tb.sv
module xcvr4_addr_match_tb;
    localparam int G = 3;

    typedef struct packed {
        logic       rx, tx;
        logic [3:0] bus;
        logic [3:0] pin;
        logic [2:0] vec, aval, acare;
        logic       men;
        logic       e_oe;
        logic [3:0] e_pout;
        logic [3:0] e_pull;
        logic       e_mpull;
    } vec_t;

    localparam int N = 10;
    localparam vec_t TBL [N] = '{
        '{1,0,4'b1010,4'b0000,3'b000,3'b010,3'b111,1, 1,4'b0101,4'b0000,0},
        '{1,0,4'b0011,4'b1111,3'b000,3'b110,3'b111,1, 1,4'b1100,4'b0000,0},
        '{0,1,4'b1111,4'b1001,3'b000,3'b000,3'b111,1, 0,4'b0000,4'b1001,0},
        '{0,1,4'b1001,4'b0110,3'b000,3'b111,3'b111,1, 0,4'b0000,4'b0110,1},
        '{0,1,4'b1001,4'b0110,3'b000,3'b111,3'b011,1, 0,4'b0000,4'b0110,0},
        '{1,1,4'b0000,4'b1111,3'b000,3'b000,3'b000,1, 0,4'b0000,4'b0000,0},
        '{0,0,4'b0000,4'b0000,3'b101,3'b111,3'b111,0, 0,4'b0000,4'b1010,1},
        '{1,0,4'b1100,4'b0000,3'b011,3'b001,3'b111,1, 1,4'b0011,4'b0110,0},
        '{0,1,4'b1111,4'b0001,3'b111,3'b000,3'b100,1, 0,4'b0000,4'b1111,0},
        '{1,0,4'b1110,4'b0000,3'b000,3'b000,3'b111,1, 1,4'b0001,4'b0000,0}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_rx, ctl_tx, match_en;
    logic [3:0] bus_in, per_in;
    logic [2:0] vec_jmp, adr_val, adr_care;
    logic [3:0] bus_pull, per_out;
    logic       per_oe, match_pull;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    xcvr4_addr_match #(.W(4), .GUARD_CYC(G)) u_dut (
        .clk(clk), .rst(rst), .ctl_rx(ctl_rx), .ctl_tx(ctl_tx),
        .bus_in(bus_in), .bus_pull(bus_pull), .per_in(per_in),
        .per_out(per_out), .per_oe(per_oe), .vec_jmp(vec_jmp),
        .adr_val(adr_val), .adr_care(adr_care), .match_en(match_en),
        .match_pull(match_pull)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ctl_rx = 1'b1; ctl_tx = 1'b0; match_en = 1'b1;
        bus_in = 4'hF; per_in = 4'hF; vec_jmp = 3'b000;
        adr_val = 3'b000; adr_care = 3'b000;
        repeat (3) @(negedge clk);
        // R1: reset holds disable even with a receive request
        chk("R1 per_oe in reset", 8'(per_oe), 8'd0);
        chk("R1 bus_pull in reset", 8'(bus_pull), 8'd0);
        ctl_rx = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 per_oe after reset", 8'(per_oe), 8'd0);

        // vector table: steady-state behaviour per mode
        for (int i = 0; i < N; i++) begin
            ctl_rx = TBL[i].rx;   ctl_tx = TBL[i].tx;
            bus_in = TBL[i].bus;  per_in = TBL[i].pin;
            vec_jmp = TBL[i].vec; adr_val = TBL[i].aval;
            adr_care = TBL[i].acare; match_en = TBL[i].men;
            repeat (G + 5) @(negedge clk);
            chk("R2 R3 R5 per_oe", 8'(per_oe), 8'(TBL[i].e_oe));
            chk("R3 R5 per_out", 8'(per_out), 8'(TBL[i].e_pout));
            chk("R4 R6 bus_pull", 8'(bus_pull), 8'(TBL[i].e_pull));
            chk("R7 R8 R9 match_pull", 8'(match_pull), 8'(TBL[i].e_mpull));
        end

        // R11: entry from settled disable
        ctl_rx = 1'b0; ctl_tx = 1'b0; vec_jmp = 3'b000; per_in = 4'hF;
        repeat (G + 5) @(negedge clk);
        ctl_rx = 1'b1;
        #1 chk("R11 not yet receiving", 8'(per_oe), 8'd0);
        @(negedge clk);
        chk("R11 receive after one edge", 8'(per_oe), 8'd1);

        // R10 / R12: receive to transmit swap
        ctl_rx = 1'b0; ctl_tx = 1'b1;
        for (int e = 1; e <= G + 1; e++) begin
            @(negedge clk);
            chk("R10 R12 guard per_oe", 8'(per_oe), 8'd0);
            chk("R10 R12 guard bus_pull", 8'(bus_pull), 8'd0);
        end
        @(negedge clk);
        chk("R10 transmit after guard", 8'(bus_pull), 8'hF);

        // R11: disable is immediate, then receive request waits out guard
        ctl_tx = 1'b0;
        @(negedge clk);
        chk("R11 disable after one edge", 8'(bus_pull), 8'd0);
        ctl_rx = 1'b1;
        repeat (G) @(negedge clk);
        chk("R11 request held during guard", 8'(per_oe), 8'd0);
        @(negedge clk);
        chk("R11 receive after guard", 8'(per_oe), 8'd1);

        // R6: vector pulls bus line 0 never, even in transmit with zero data
        ctl_rx = 1'b0; ctl_tx = 1'b1; per_in = 4'h0; vec_jmp = 3'b111;
        repeat (G + 5) @(negedge clk);
        chk("R6 vector lines only", 8'(bus_pull), 8'hE);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule